// File: doc/BRIEF.md
# Dual-Space MDIO Management Slave

This block is a management-bus slave that runs entirely on the MDC clock. It sees the serial data line as three signals: an input, an output and an output enable. It decodes clause-22 frames of the form preamble, start, opcode, PHY field, register field, turnaround and 16 data bits. Bit 2 of the PHY field selects one of two register spaces.

With that bit clear, the frame targets a standard space of six 16-bit registers. The slave answers only if the low two PHY bits match a strapped address. With that bit set, the frame targets a flat bank of 128 byte-wide configuration registers. In that case the two upper PHY bits are joined to the register field to form a 7-bit index.

All storage lives inside the block. A parallel port lets local logic read any register combinationally and update it synchronously. Every management write that is stored raises a one-cycle pulse on that port, together with the space and the index written.

Top module: `mdioSlave`

## Requirements
- R1: A frame is recognised only after at least 32 consecutive ones sampled on MDIO, followed by the start pattern 0 then 1. With fewer ones, the slave ignores the frame and never drives the line.
- R2: Opcode 10 is a read and opcode 01 is a write. Opcodes 00 and 11, or a start pattern other than 01, abandon the frame without driving the line.
- R3: With PHY bit 2 equal to 0, the slave serves six 16-bit standard registers (index 0 to 5), MSB first. It responds only when PHY bits [1:0] equal `phyAddrCfg`. PHY bits [4:3] have no effect.
- R4: In the standard space, a read of an index above 5 drives 0x0000, and a write to such an index is discarded with no write pulse.
- R5: With PHY bit 2 equal to 1, the slave serves 128 byte registers at index {PHY[4:3], REG[4:0]}. PHY bits [1:0] have no effect, and no address match is required.
- R6: In the configuration space, a read drives 0x00 in the upper byte followed by the stored byte. A write stores only the low 8 data bits.
- R7: On a read, the line is released during the first turnaround bit and driven 0 during the second. It is then driven with the 16 data bits and released after the last one. The output changes only on falling MDC edges; MDIO is sampled on rising edges.
- R8: A write is committed on the rising edge that samples the 16th data bit. For the following MDC cycle, `mgmtWrPulse` is 1, with `mgmtWrExt` giving the space (1 for configuration) and `mgmtWrIdx` the index.
- R9: `locRdData` shows the register addressed by `locStdSel`/`locIdx` (standard indices above 5 read 0; configuration bytes are zero-extended). `locWrEn` stores `locWrData` on the next rising MDC edge, and a later management read returns the stored value.
- R10: After an aborted frame, the slave hunts for a new preamble and serves the next valid frame normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mdioIn | input | 1 | Sampled MDIO line |
| mdioOut | output | 1 | Value driven onto MDIO |
| mdioOe | output | 1 | MDIO output enable |
| phyAddrCfg | input | 2 | Strapped low PHY address for the standard space |
| locStdSel | input | 1 | Local port space: 1 standard, 0 configuration |
| locIdx | input | 7 | Local port register index |
| locWrEn | input | 1 | Local write strobe |
| locWrData | input | 16 | Local write data (low byte used for configuration) |
| locRdData | output | 16 | Local read data |
| mgmtWrPulse | output | 1 | One-cycle pulse after a stored management write |
| mgmtWrExt | output | 1 | Space of the last stored management write |
| mgmtWrIdx | output | 7 | Index of the last stored management write |

## Verification
The assertions check, on every cycle, the properties that can be judged locally. The line is never enabled outside a matched read's turnaround or data phase. The first turnaround bit is always released and the second is driven low. A configuration-space load always leaves a zero upper byte in the shift register. The write pulse never lasts two cycles, the preamble counter stays bounded, and the header phase is entered only with a legal opcode. Other behaviour can only be shown by the bench's frame scenarios. These include the mapping of PHY bits into the 7-bit index, the address match and the don't-care bits, the zero response above index 5, discarded writes, and recovery after short preambles, bad start patterns and bad opcodes.

// File: rtl/mdioPkg.sv
package mdioPkg;
  localparam int PRE_LEN   = 32;
  localparam int DATA_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int STD_NUM   = 6;
  localparam int EXT_DEPTH = 128;
  localparam int IDX_W     = $clog2(EXT_DEPTH);

  typedef enum logic [2:0] {
    ST_HUNT, ST_SOF, ST_OPC, ST_HDR, ST_TURN, ST_DATA
  } frameState_t;

  typedef struct packed {
    logic             loadRd;
    logic             shiftEn;
    logic             commit;
    logic             taFirst;
    logic             drvTa;
    logic             drvData;
    logic             extSpace;
    logic [IDX_W-1:0] regIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/mdioCtrl.sv
module mdioCtrl
  import mdioPkg::*;
#(
  parameter int PRE_BITS = PRE_LEN,
  parameter int WORD_W   = DATA_W
) (
  input  logic       mdc,
  input  logic       rstN,
  input  logic       mdioIn,
  input  logic [1:0] phyAddrCfg,
  output ctlStrobe_t strb
);
  localparam int PRE_CW = $clog2(PRE_BITS + 1);
  localparam int HDR_W  = 10;

  frameState_t      state;
  logic [PRE_CW-1:0] preCnt;
  logic [4:0]        bitCnt;
  logic              opFirst;
  logic [1:0]        opReg;
  logic              isRead;
  logic [HDR_W-1:0]  hdr;

  logic [4:0] hdrPhy;
  logic [4:0] hdrReg;
  logic       hit;

  assign hdrPhy = hdr[9:5];
  assign hdrReg = hdr[4:0];
  assign hit    = hdrPhy[2] | (hdrPhy[1:0] == phyAddrCfg);

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      preCnt  <= '0;
      bitCnt  <= '0;
      opFirst <= 1'b0;
      opReg   <= '0;
      isRead  <= 1'b0;
      hdr     <= '0;
    end else begin
      unique case (state)
        ST_HUNT: begin
          if (mdioIn) begin
            if (preCnt != PRE_CW'(PRE_BITS)) preCnt <= preCnt + 1'b1;
          end else begin
            if (preCnt == PRE_CW'(PRE_BITS)) state <= ST_SOF;
            preCnt <= '0;
          end
        end
        ST_SOF: begin
          state  <= mdioIn ? ST_OPC : ST_HUNT;
          bitCnt <= '0;
        end
        ST_OPC: begin
          opFirst <= mdioIn;
          bitCnt  <= bitCnt + 1'b1;
          if (bitCnt == 5'd1) begin
            bitCnt <= '0;
            if (opFirst != mdioIn) begin
              opReg  <= {opFirst, mdioIn};
              isRead <= opFirst;
              state  <= ST_HDR;
            end else begin
              state <= ST_HUNT;
            end
          end
        end
        ST_HDR: begin
          hdr    <= {hdr[HDR_W-2:0], mdioIn};
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == 5'(HDR_W - 1)) begin
            bitCnt <= '0;
            state  <= ST_TURN;
          end
        end
        ST_TURN: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == 5'd1) begin
            bitCnt <= '0;
            state  <= ST_DATA;
          end
        end
        ST_DATA: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == 5'(WORD_W - 1)) begin
            bitCnt <= '0;
            state  <= ST_HUNT;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.extSpace = hdrPhy[2];
    strb.regIdx   = hdrPhy[2] ? {hdrPhy[4:3], hdrReg} : {2'b00, hdrReg};
    strb.taFirst  = (state == ST_TURN) && (bitCnt == 5'd0);
    strb.loadRd   = strb.taFirst && isRead && hit;
    strb.drvTa    = (state == ST_TURN) && (bitCnt == 5'd1) && isRead && hit;
    strb.shiftEn  = (state == ST_DATA);
    strb.drvData  = (state == ST_DATA) && isRead && hit;
    strb.commit   = (state == ST_DATA) && (bitCnt == 5'(WORD_W - 1)) && !isRead && hit;
  end

  AST_PRE_BOUND: assert property (@(posedge mdc) disable iff (!rstN)
    preCnt <= PRE_CW'(PRE_BITS)); // R1
  AST_HDR_LEGAL_OP: assert property (@(posedge mdc) disable iff (!rstN)
    (state == ST_HDR) |-> (opReg == 2'b10 || opReg == 2'b01)); // R2
endmodule

// File: rtl/mdioDatapath.sv
module mdioDatapath
  import mdioPkg::*;
#(
  parameter int WORD_W  = DATA_W,
  parameter int BYTE_WD = BYTE_W,
  parameter int STD_CNT = STD_NUM,
  parameter int EXT_CNT = EXT_DEPTH,
  parameter int IDX_WD  = IDX_W
) (
  input  logic              mdc,
  input  logic              rstN,
  input  logic              mdioIn,
  input  ctlStrobe_t        strb,
  input  logic              locStdSel,
  input  logic [IDX_WD-1:0] locIdx,
  input  logic              locWrEn,
  input  logic [WORD_W-1:0] locWrData,
  output logic [WORD_W-1:0] locRdData,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic              wrPulse,
  output logic              wrExt,
  output logic [IDX_WD-1:0] wrIdx
);
  localparam int STD_AW = $clog2(STD_CNT);
  localparam int PAD_W  = WORD_W - BYTE_WD;

  logic [WORD_W-1:0]  stdRegs [STD_CNT];
  logic [BYTE_WD-1:0] extRegs [EXT_CNT];
  logic [WORD_W-1:0]  shiftReg;
  logic [WORD_W-1:0]  rdWord;
  logic [WORD_W-1:0]  wrWord;
  logic               stdHit;
  logic               locStdHit;

  assign stdHit    = strb.regIdx < IDX_WD'(STD_CNT);
  assign locStdHit = locIdx < IDX_WD'(STD_CNT);
  assign wrWord    = {shiftReg[WORD_W-2:0], mdioIn};

  always_comb begin
    if (strb.extSpace)  rdWord = {{PAD_W{1'b0}}, extRegs[strb.regIdx]};
    else if (stdHit)    rdWord = stdRegs[strb.regIdx[STD_AW-1:0]];
    else                rdWord = '0;
    if (!locStdSel)     locRdData = {{PAD_W{1'b0}}, extRegs[locIdx]};
    else if (locStdHit) locRdData = stdRegs[locIdx[STD_AW-1:0]];
    else                locRdData = '0;
  end

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STD_CNT; i++) stdRegs[i] <= '0;
      for (int i = 0; i < EXT_CNT; i++) extRegs[i] <= '0;
      shiftReg <= '0;
      wrPulse  <= 1'b0;
      wrExt    <= 1'b0;
      wrIdx    <= '0;
    end else begin
      wrPulse <= 1'b0;
      if (locWrEn) begin
        if (!locStdSel)     extRegs[locIdx] <= locWrData[BYTE_WD-1:0];
        else if (locStdHit) stdRegs[locIdx[STD_AW-1:0]] <= locWrData;
      end
      if (strb.loadRd)       shiftReg <= rdWord;
      else if (strb.shiftEn) shiftReg <= wrWord;
      if (strb.commit && (strb.extSpace || stdHit)) begin
        if (strb.extSpace) extRegs[strb.regIdx] <= wrWord[BYTE_WD-1:0];
        else               stdRegs[strb.regIdx[STD_AW-1:0]] <= wrWord;
        wrPulse <= 1'b1;
        wrExt   <= strb.extSpace;
        wrIdx   <= strb.regIdx;
      end
    end
  end

  always_ff @(negedge mdc or negedge rstN) begin
    if (!rstN) begin
      mdioOe  <= 1'b0;
      mdioOut <= 1'b0;
    end else begin
      mdioOe  <= strb.drvTa | strb.drvData;
      mdioOut <= strb.drvData ? shiftReg[WORD_W-1] : 1'b0;
    end
  end

  AST_OE_READ_ONLY: assert property (@(posedge mdc) disable iff (!rstN)
    mdioOe |-> (strb.drvTa || strb.drvData)); // R7
  AST_TA_RELEASE: assert property (@(posedge mdc) disable iff (!rstN)
    strb.taFirst |-> !mdioOe); // R7
  AST_TA_LOW: assert property (@(posedge mdc) disable iff (!rstN)
    strb.drvTa |-> (mdioOe && !mdioOut)); // R7
  AST_EXT_UPPER_ZERO: assert property (@(posedge mdc) disable iff (!rstN)
    (strb.loadRd && strb.extSpace) |=> (shiftReg[WORD_W-1:BYTE_WD] == '0)); // R6
  AST_PULSE_SINGLE: assert property (@(posedge mdc) disable iff (!rstN)
    wrPulse |=> !wrPulse); // R8
endmodule

// File: rtl/mdioSlave.sv
module mdioSlave
  import mdioPkg::*;
(
  input  logic              mdc,
  input  logic              rstN,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic [1:0]        phyAddrCfg,
  input  logic              locStdSel,
  input  logic [IDX_W-1:0]  locIdx,
  input  logic              locWrEn,
  input  logic [DATA_W-1:0] locWrData,
  output logic [DATA_W-1:0] locRdData,
  output logic              mgmtWrPulse,
  output logic              mgmtWrExt,
  output logic [IDX_W-1:0]  mgmtWrIdx
);
  ctlStrobe_t strb;

  mdioCtrl #(.PRE_BITS(PRE_LEN), .WORD_W(DATA_W)) uCtrl (
    .mdc(mdc), .rstN(rstN), .mdioIn(mdioIn), .phyAddrCfg(phyAddrCfg), .strb(strb)
  );

  mdioDatapath #(
    .WORD_W(DATA_W), .BYTE_WD(BYTE_W), .STD_CNT(STD_NUM),
    .EXT_CNT(EXT_DEPTH), .IDX_WD(IDX_W)
  ) uData (
    .mdc(mdc), .rstN(rstN), .mdioIn(mdioIn), .strb(strb),
    .locStdSel(locStdSel), .locIdx(locIdx), .locWrEn(locWrEn),
    .locWrData(locWrData), .locRdData(locRdData),
    .mdioOut(mdioOut), .mdioOe(mdioOe),
    .wrPulse(mgmtWrPulse), .wrExt(mgmtWrExt), .wrIdx(mgmtWrIdx)
  );
endmodule

// File: tb/mdioSlave_test.sv
module mdioSlave_test;
  localparam int CLK_PERIOD = 20;

  logic        mdc = 1'b0;
  logic        rstN = 1'b0;
  logic        mdioIn = 1'b1;
  logic        mdioOut, mdioOe;
  logic [1:0]  phyAddrCfg = 2'b10;
  logic        locStdSel = 1'b0;
  logic [6:0]  locIdx = '0;
  logic        locWrEn = 1'b0;
  logic [15:0] locWrData = '0;
  logic [15:0] locRdData;
  logic        mgmtWrPulse, mgmtWrExt;
  logic [6:0]  mgmtWrIdx;

  int checks = 0;
  int failures = 0;
  bit oeSeen;
  bit pulseSeen, pulseExt;
  logic [6:0] pulseIdx;
  logic [15:0] rd;
  bit ta1Z, ta2Zero, idleAfter;

  mdioSlave uut (
    .mdc(mdc), .rstN(rstN), .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .phyAddrCfg(phyAddrCfg), .locStdSel(locStdSel), .locIdx(locIdx),
    .locWrEn(locWrEn), .locWrData(locWrData), .locRdData(locRdData),
    .mgmtWrPulse(mgmtWrPulse), .mgmtWrExt(mgmtWrExt), .mgmtWrIdx(mgmtWrIdx)
  );

  always #(CLK_PERIOD/2) mdc = ~mdc;
  always @(posedge mdc) if (mdioOe) oeSeen = 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge mdc);
    mdioIn = b;
  endtask

  task automatic sendBits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sendBit(v[i]);
  endtask

  // Full frame; read-form (op 10) samples the line, otherwise writes wd.
  task automatic runFrame(input int preLen, input logic [1:0] sof, input logic [1:0] op,
                          input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
    oeSeen = 1'b0; pulseSeen = 1'b0; rd = '0;
    for (int i = 0; i < preLen; i++) sendBit(1'b1);
    sendBits({14'd0, sof}, 2);
    sendBits({14'd0, op}, 2);
    sendBits({11'd0, phy}, 5);
    sendBits({11'd0, rg}, 5);
    if (op == 2'b10) begin
      @(negedge mdc); mdioIn = 1'b1; #(CLK_PERIOD/4); ta1Z = !mdioOe;
      @(negedge mdc); #(CLK_PERIOD/4); ta2Zero = mdioOe && !mdioOut;
      for (int i = 0; i < 16; i++) begin
        @(negedge mdc); #(CLK_PERIOD/4);
        rd = {rd[14:0], mdioOe ? mdioOut : 1'b1};
      end
      @(negedge mdc); #(CLK_PERIOD/4); idleAfter = !mdioOe;
    end else begin
      sendBit(1'b1); sendBit(1'b0);
      sendBits(wd, 16);
      @(negedge mdc); mdioIn = 1'b1; #1;
      pulseSeen = mgmtWrPulse; pulseExt = mgmtWrExt; pulseIdx = mgmtWrIdx;
    end
    repeat (2) sendBit(1'b1);
  endtask

  task automatic localRead(input logic sel, input logic [6:0] idx, output logic [15:0] v);
    @(negedge mdc); locStdSel = sel; locIdx = idx; #1; v = locRdData;
  endtask

  task automatic localWrite(input logic sel, input logic [6:0] idx, input logic [15:0] v);
    @(negedge mdc); locStdSel = sel; locIdx = idx; locWrData = v; locWrEn = 1'b1;
    @(negedge mdc); locWrEn = 1'b0;
  endtask

  task automatic testReset();
    logic [15:0] v;
    #1;
    check(!mdioOe, "R7", "reset oe", mdioOe, 0);
    check(!mgmtWrPulse, "R8", "reset pulse", mgmtWrPulse, 0);
    localRead(1'b0, 7'h46, v); check(v == 16'h0, "R9", "reset ext reg", v, 0);
    localRead(1'b1, 7'd3, v);  check(v == 16'h0, "R9", "reset std reg", v, 0);
  endtask

  task automatic testStdSpace();
    logic [15:0] v;
    runFrame(32, 2'b01, 2'b01, 5'b11010, 5'd3, 16'hA5C3);
    check(pulseSeen && !pulseExt && pulseIdx == 7'd3, "R8", "std write pulse/idx",
          {pulseSeen, pulseExt, pulseIdx}, {2'b10, 7'd3});
    localRead(1'b1, 7'd3, v); check(v == 16'hA5C3, "R3", "std stored word", v, 16'hA5C3);
    runFrame(32, 2'b01, 2'b10, 5'b00010, 5'd3, 16'h0);
    check(rd == 16'hA5C3, "R3", "std read back (bits 4:3 differ)", rd, 16'hA5C3);
    check(ta1Z, "R7", "TA first bit released", ta1Z, 1);
    check(ta2Zero, "R7", "TA second bit driven 0", ta2Zero, 1);
    check(idleAfter, "R7", "released after data", idleAfter, 1);
    runFrame(32, 2'b01, 2'b10, 5'b00001, 5'd3, 16'h0);
    check(!oeSeen, "R3", "std read other PHY no drive", oeSeen, 0);
    runFrame(32, 2'b01, 2'b01, 5'b00001, 5'd3, 16'h1111);
    localRead(1'b1, 7'd3, v);
    check(v == 16'hA5C3 && !pulseSeen, "R3", "std write other PHY ignored", v, 16'hA5C3);
  endtask

  task automatic testStdHighIndex();
    logic [15:0] v;
    runFrame(32, 2'b01, 2'b01, 5'b00010, 5'd7, 16'hFFFF);
    check(!pulseSeen, "R4", "write idx 7 no pulse", pulseSeen, 0);
    localRead(1'b1, 7'd7, v); check(v == 16'h0, "R4", "idx 7 local read", v, 0);
    runFrame(32, 2'b01, 2'b10, 5'b00010, 5'd7, 16'h0);
    check(rd == 16'h0000 && oeSeen, "R4", "read idx 7 drives zero", rd, 0);
  endtask

  task automatic testExtSpace();
    logic [15:0] v;
    runFrame(32, 2'b01, 2'b01, 5'b10101, 5'b00110, 16'hBE7F);
    check(pulseSeen && pulseExt && pulseIdx == 7'h46, "R8", "ext write pulse/idx",
          {pulseSeen, pulseExt, pulseIdx}, {2'b11, 7'h46});
    localRead(1'b0, 7'h46, v); check(v == 16'h007F, "R6", "ext low byte stored", v, 16'h007F);
    localRead(1'b0, 7'h06, v); check(v == 16'h0, "R5", "ext idx 0x06 untouched", v, 0);
    runFrame(32, 2'b01, 2'b10, 5'b10110, 5'b00110, 16'h0);
    check(rd == 16'h007F, "R6", "ext read zero upper byte", rd, 16'h007F);
    check(ta1Z && ta2Zero, "R7", "ext turnaround", {ta1Z, ta2Zero}, 2'b11);
    phyAddrCfg = 2'b00;
    runFrame(32, 2'b01, 2'b10, 5'b10111, 5'b00110, 16'h0);
    check(rd == 16'h007F, "R5", "ext read ignores PHY[1:0]", rd, 16'h007F);
    phyAddrCfg = 2'b10;
  endtask

  task automatic testLocalPort();
    logic [15:0] v;
    localWrite(1'b0, 7'h7F, 16'hAB3C);
    runFrame(32, 2'b01, 2'b10, 5'b11100, 5'b11111, 16'h0);
    check(rd == 16'h003C, "R9", "local ext write seen by read", rd, 16'h003C);
    localWrite(1'b1, 7'd0, 16'h1234);
    localRead(1'b1, 7'd0, v); check(v == 16'h1234, "R9", "local std read", v, 16'h1234);
    runFrame(32, 2'b01, 2'b10, 5'b00010, 5'd0, 16'h0);
    check(rd == 16'h1234, "R9", "local std write seen by read", rd, 16'h1234);
  endtask

  task automatic testAbort();
    logic [15:0] v;
    runFrame(20, 2'b01, 2'b10, 5'b00010, 5'd3, 16'h0);
    check(!oeSeen, "R1", "short preamble no drive", oeSeen, 0);
    runFrame(32, 2'b01, 2'b11, 5'b00010, 5'd3, 16'h0);
    check(!oeSeen, "R2", "opcode 11 no drive", oeSeen, 0);
    runFrame(32, 2'b00, 2'b10, 5'b00010, 5'd3, 16'h0);
    check(!oeSeen, "R2", "bad start no drive", oeSeen, 0);
    runFrame(32, 2'b01, 2'b00, 5'b00010, 5'd3, 16'h5555);
    localRead(1'b1, 7'd3, v);
    check(v == 16'hA5C3 && !pulseSeen, "R2", "opcode 00 write ignored", v, 16'hA5C3);
    runFrame(32, 2'b01, 2'b10, 5'b00010, 5'd3, 16'h0);
    check(rd == 16'hA5C3, "R10", "valid read after aborts", rd, 16'hA5C3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge mdc);
    testReset();
    rstN = 1'b1;
    testStdSpace();
    testStdHighIndex();
    testExtSpace();
    testLocalPort();
    testAbort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule